// File: doc/BRIEF.md
# One-Way Lifecycle and Protection Controller

This block holds a device lifecycle stage in a set of one-way, fuse-like bits. From that stage it derives a protection state and a per-port debug enable mask. It also gates the jump from boot firmware into user code. The stage register is cleared only by a power-on (fuse) reset. Every other piece of state restarts on the warm reset.

Software asks for a stage change through a request strobe that carries a target stage. Legal moves set additional stage bits. Illegal moves are refused and flagged. After each warm reset, a boot sequencer waits a fixed setup time. In the two secure stages it then waits for a hash comparison result, followed by a signature verification result. Both results arrive as pass/fail inputs with valid strobes from engines outside the block.

Any failed or misordered check drops the block into a DEAD protection state. In DEAD the debug mask comes from a dead-state restriction register. That register was programmed earlier and is locked once the stage reaches SECURE or RMA.

Top module: `lifecycle_prot_ctrl`

## Requirements
- R1: After fuse reset and warm reset, stage_o is 000, prot_o is 0 (normal), dbg_en_o is all ones, and adv_err_o and jump_o are low.
- R2: stage_o always holds a thermometer code: 000 normal, 001 secure-with-debug, 011 secure, 111 RMA. The adv_target_i codes are 0 normal, 1 secure-with-debug, 2 secure and 3 RMA.
- R3: These requests are legal: normal to secure-with-debug, normal to secure, and any non-RMA stage to RMA. stage_o takes the new code in the cycle after the request, and adv_err_o stays low.
- R4: All other requests are refused, and stage_o is left unchanged. This covers same-stage requests, backward moves, secure-with-debug to secure, and any request from RMA. adv_err_o is high for exactly the cycle after the request. Stage bits are only ever set.
- R5: A warm reset (rst_ni) leaves stage_o unchanged. Only fuse_rst_ni clears it.
- R6: In the normal and RMA stages, jump_o rises SETUP_CYCLES clock edges after the warm reset is released. No checks are needed, and check strobes are ignored.
- R7: In the secure and secure-with-debug stages, jump_o rises only after a passing hash strobe is followed by a passing signature strobe.
- R8: A failing hash or signature result sets prot_o to 4 (DEAD) and holds jump_o low. DEAD persists until the next warm reset, and the checks then run again.
- R9: In a secure stage, an out-of-order strobe leads to DEAD. Out of order means a signature strobe before the hash has passed, a second hash strobe, or any strobe during setup.
- R10: dbg_en_o is all ones in normal, secure-with-debug and RMA. It is all zeros in secure. In DEAD it equals the dead-state restriction register.
- R11: Writes to the dead-state restriction register (dar_we_i/dar_wdata_i) take effect in the normal and secure-with-debug stages. They are ignored once stage_o is 011 or 111.
- R12: Outside DEAD, prot_o follows the live stage: 0, 1, 2 or 3 for the four stages, including advances made after boot has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| fuse_rst_ni | input | 1 | Active-low async power-on reset for the stage bits and restriction register |
| rst_ni | input | 1 | Active-low async warm reset for the boot sequencer |
| adv_req_i | input | 1 | Stage advance request strobe |
| adv_target_i | input | 2 | Requested target stage code |
| hash_valid_i | input | 1 | Hash comparison result strobe |
| hash_pass_i | input | 1 | Hash comparison passed |
| sig_valid_i | input | 1 | Signature verification result strobe |
| sig_pass_i | input | 1 | Signature verification passed |
| dar_we_i | input | 1 | Dead-state restriction register write enable |
| dar_wdata_i | input | DBG_PORTS | Dead-state restriction write data |
| stage_o | output | 3 | Thermometer-coded lifecycle stage |
| adv_err_o | output | 1 | One-cycle refused-request flag |
| prot_o | output | 3 | Protection state (0..3 stages, 4 DEAD) |
| dbg_en_o | output | DBG_PORTS | Per-port debug enable mask |
| jump_o | output | 1 | Permission to jump to user code |

## Verification
The bench builds the block with DBG_PORTS = 4 and SETUP_CYCLES = 3. The short setup window makes it practical to send strobes inside setup, and to count the exact edge at which jump_o rises. The four-bit mask is wide enough for distinct restriction patterns to tell a locked write apart from an accepted one once DEAD is entered. Every advance from every stage is exercised, and so is DEAD reached by each failure and ordering path.

// File: rtl/lifecycle_pkg.sv
package lifecycle_pkg;

  typedef enum logic [1:0] {
    TGT_NORMAL = 2'd0,
    TGT_SECDBG = 2'd1,
    TGT_SECURE = 2'd2,
    TGT_RMA    = 2'd3
  } lc_target_e;

  localparam int unsigned STAGE_W = 3;
  localparam logic [STAGE_W-1:0] STG_NORMAL = 3'b000;
  localparam logic [STAGE_W-1:0] STG_SECDBG = 3'b001;
  localparam logic [STAGE_W-1:0] STG_SECURE = 3'b011;
  localparam logic [STAGE_W-1:0] STG_RMA    = 3'b111;

  typedef enum logic [2:0] {
    PROT_NORMAL = 3'd0,
    PROT_SECDBG = 3'd1,
    PROT_SECURE = 3'd2,
    PROT_RMA    = 3'd3,
    PROT_DEAD   = 3'd4
  } prot_e;

  typedef enum logic [2:0] {
    BS_SETUP,
    BS_HASH,
    BS_SIG,
    BS_DONE,
    BS_DEAD
  } boot_e;

  function automatic logic [STAGE_W-1:0] target_code(lc_target_e t);
    unique case (t)
      TGT_NORMAL: return STG_NORMAL;
      TGT_SECDBG: return STG_SECDBG;
      TGT_SECURE: return STG_SECURE;
      default:    return STG_RMA;
    endcase
  endfunction

endpackage

// File: rtl/lc_stage_reg.sv
module lc_stage_reg
  import lifecycle_pkg::*;
(
  input  logic               clk_i,
  input  logic               fuse_rst_ni,
  input  logic               adv_req_i,
  input  lc_target_e         adv_target_i,
  output logic [STAGE_W-1:0] stage_o,
  output logic               adv_err_o
);

  logic [STAGE_W-1:0] stage_q;
  logic               err_q;
  logic               legal;

  always_comb begin
    legal = 1'b0;
    if (adv_target_i == TGT_RMA) begin
      legal = (stage_q != STG_RMA);
    end else if (stage_q == STG_NORMAL) begin
      legal = (adv_target_i == TGT_SECDBG) || (adv_target_i == TGT_SECURE);
    end
  end

  always_ff @(posedge clk_i or negedge fuse_rst_ni) begin
    if (!fuse_rst_ni) begin
      stage_q <= STG_NORMAL;
      err_q   <= 1'b0;
    end else begin
      err_q <= adv_req_i && !legal;
      // set-only update: bits are never cleared
      if (adv_req_i && legal) stage_q <= stage_q | target_code(adv_target_i);
    end
  end

  assign stage_o   = stage_q;
  assign adv_err_o = err_q;

  p_therm_code_r2: assert property (@(posedge clk_i) disable iff (!fuse_rst_ni)
    (stage_q == STG_NORMAL) || (stage_q == STG_SECDBG) ||
    (stage_q == STG_SECURE) || (stage_q == STG_RMA));

  p_bits_only_set_r4: assert property (@(posedge clk_i) disable iff (!fuse_rst_ni)
    ((stage_q & $past(stage_q)) == $past(stage_q)));

  p_secdbg_refuse_r4: assert property (@(posedge clk_i) disable iff (!fuse_rst_ni)
    (adv_req_i && stage_q == STG_SECDBG && adv_target_i == TGT_SECURE)
    |=> (adv_err_o && stage_o == STG_SECDBG));

endmodule

// File: rtl/lc_boot_seq.sv
module lc_boot_seq
  import lifecycle_pkg::*;
#(
  parameter int unsigned SETUP_CYCLES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STAGE_W-1:0] stage_i,
  input  logic               hash_valid_i,
  input  logic               hash_pass_i,
  input  logic               sig_valid_i,
  input  logic               sig_pass_i,
  output logic               dead_o,
  output logic               jump_o
);

  localparam int unsigned CNT_W = $clog2(SETUP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETUP_CYCLES - 1);

  boot_e            state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             chk_now;

  assign chk_now = (stage_i == STG_SECDBG) || (stage_i == STG_SECURE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      BS_SETUP: begin
        if (chk_now && (hash_valid_i || sig_valid_i)) state_d = BS_DEAD;
        else if (cnt_q == CNT_LAST) state_d = chk_now ? BS_HASH : BS_DONE;
        else cnt_d = cnt_q + 1'b1;
      end
      BS_HASH: begin
        if (sig_valid_i || (hash_valid_i && !hash_pass_i)) state_d = BS_DEAD;
        else if (hash_valid_i) state_d = BS_SIG;
      end
      BS_SIG: begin
        if (hash_valid_i || (sig_valid_i && !sig_pass_i)) state_d = BS_DEAD;
        else if (sig_valid_i) state_d = BS_DONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BS_SETUP;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign dead_o = (state_q == BS_DEAD);
  assign jump_o = (state_q == BS_DONE);

  p_dead_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |=> dead_o);

  p_sig_early_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BS_HASH && sig_valid_i) |=> dead_o);

  p_jump_after_sig_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BS_SIG && !jump_o) ##1 jump_o |-> $past(sig_valid_i && sig_pass_i));

endmodule

// File: rtl/lc_dead_policy.sv
module lc_dead_policy #(
  parameter int unsigned DBG_PORTS = 4
) (
  input  logic                 clk_i,
  input  logic                 fuse_rst_ni,
  input  logic                 lock_i,
  input  logic                 we_i,
  input  logic [DBG_PORTS-1:0] wdata_i,
  output logic [DBG_PORTS-1:0] mask_o
);

  logic [DBG_PORTS-1:0] mask_q;

  always_ff @(posedge clk_i or negedge fuse_rst_ni) begin
    if (!fuse_rst_ni) mask_q <= '0;
    else if (we_i && !lock_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  p_locked_stable_r11: assert property (@(posedge clk_i) disable iff (!fuse_rst_ni)
    lock_i |=> $stable(mask_o));

endmodule

// File: rtl/lifecycle_prot_ctrl.sv
module lifecycle_prot_ctrl
  import lifecycle_pkg::*;
#(
  parameter int unsigned DBG_PORTS    = 4,
  parameter int unsigned SETUP_CYCLES = 16
) (
  input  logic                 clk_i,
  input  logic                 fuse_rst_ni,
  input  logic                 rst_ni,
  input  logic                 adv_req_i,
  input  logic [1:0]           adv_target_i,
  input  logic                 hash_valid_i,
  input  logic                 hash_pass_i,
  input  logic                 sig_valid_i,
  input  logic                 sig_pass_i,
  input  logic                 dar_we_i,
  input  logic [DBG_PORTS-1:0] dar_wdata_i,
  output logic [2:0]           stage_o,
  output logic                 adv_err_o,
  output logic [2:0]           prot_o,
  output logic [DBG_PORTS-1:0] dbg_en_o,
  output logic                 jump_o
);

  logic [STAGE_W-1:0]   stage;
  logic                 dead;
  logic [DBG_PORTS-1:0] dead_mask;
  prot_e                prot;
  logic                 all_open;

  lc_stage_reg i_stage (
    .clk_i       (clk_i),
    .fuse_rst_ni (fuse_rst_ni),
    .adv_req_i   (adv_req_i),
    .adv_target_i(lc_target_e'(adv_target_i)),
    .stage_o     (stage),
    .adv_err_o   (adv_err_o)
  );

  lc_boot_seq #(.SETUP_CYCLES(SETUP_CYCLES)) i_boot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stage_i     (stage),
    .hash_valid_i(hash_valid_i),
    .hash_pass_i (hash_pass_i),
    .sig_valid_i (sig_valid_i),
    .sig_pass_i  (sig_pass_i),
    .dead_o      (dead),
    .jump_o      (jump_o)
  );

  // lock once the secure bit (bit 1) is set: secure or RMA
  lc_dead_policy #(.DBG_PORTS(DBG_PORTS)) i_dead (
    .clk_i      (clk_i),
    .fuse_rst_ni(fuse_rst_ni),
    .lock_i     (stage[1]),
    .we_i       (dar_we_i),
    .wdata_i    (dar_wdata_i),
    .mask_o     (dead_mask)
  );

  always_comb begin
    if (dead) prot = PROT_DEAD;
    else begin
      unique case (stage)
        STG_NORMAL: prot = PROT_NORMAL;
        STG_SECDBG: prot = PROT_SECDBG;
        STG_RMA:    prot = PROT_RMA;
        default:    prot = PROT_SECURE;
      endcase
    end
  end

  assign all_open = (prot != PROT_SECURE);

  for (genvar g = 0; g < DBG_PORTS; g++) begin : g_dbg
    assign dbg_en_o[g] = (prot == PROT_DEAD) ? dead_mask[g] : all_open;
  end

  assign stage_o = stage;
  assign prot_o  = prot;

  p_secure_closed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !fuse_rst_ni)
    (prot_o == PROT_SECURE) |-> (dbg_en_o == '0));

  p_dead_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !fuse_rst_ni)
    (prot_o == PROT_DEAD) |-> (dbg_en_o == dead_mask));

  p_no_jump_dead_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !fuse_rst_ni)
    jump_o |-> (prot_o != PROT_DEAD));

endmodule

// File: tb/test_lifecycle_prot_ctrl.sv
`timescale 1ns/1ps
module test_lifecycle_prot_ctrl;

  localparam int unsigned P = 4;
  localparam int unsigned S = 3;

  logic clk = 1'b0;
  logic fuse_rst_n = 1'b0, rst_n = 1'b0;
  logic adv_req = 1'b0;
  logic [1:0] adv_tgt = '0;
  logic hv = 1'b0, hp = 1'b0, sv = 1'b0, sp = 1'b0;
  logic dar_we = 1'b0;
  logic [P-1:0] dar_wd = '0;
  logic [2:0] stage, prot;
  logic adv_err, jump;
  logic [P-1:0] dbg;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  lifecycle_prot_ctrl #(.DBG_PORTS(P), .SETUP_CYCLES(S)) i_lifecycle_prot_ctrl (
    .clk_i(clk), .fuse_rst_ni(fuse_rst_n), .rst_ni(rst_n),
    .adv_req_i(adv_req), .adv_target_i(adv_tgt),
    .hash_valid_i(hv), .hash_pass_i(hp), .sig_valid_i(sv), .sig_pass_i(sp),
    .dar_we_i(dar_we), .dar_wdata_i(dar_wd),
    .stage_o(stage), .adv_err_o(adv_err), .prot_o(prot), .dbg_en_o(dbg), .jump_o(jump)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fuse_reset();
    @(negedge clk); fuse_rst_n = 1'b0; rst_n = 1'b0;
    @(negedge clk); fuse_rst_n = 1'b1; rst_n = 1'b1;
  endtask

  task automatic warm_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wait_setup();
    repeat (S) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic adv(input logic [1:0] t);
    @(negedge clk); adv_req = 1'b1; adv_tgt = t;
    @(negedge clk); adv_req = 1'b0;
  endtask

  task automatic dar_write(input logic [P-1:0] d);
    @(negedge clk); dar_we = 1'b1; dar_wd = d;
    @(negedge clk); dar_we = 1'b0;
  endtask

  task automatic hash_strobe(input logic pass);
    hv = 1'b1; hp = pass;
    @(negedge clk); hv = 1'b0; hp = 1'b0;
  endtask

  task automatic sig_strobe(input logic pass);
    sv = 1'b1; sp = pass;
    @(negedge clk); sv = 1'b0; sp = 1'b0;
  endtask

  task automatic t_reset();
    fuse_reset();
    check("R1 stage", stage, 3'b000);
    check("R1 prot", prot, 0);
    check("R1 dbg", dbg, 4'hF);
    check("R1 err", adv_err, 0);
    check("R1 jump", jump, 0);
    repeat (S - 1) @(posedge clk);
    @(negedge clk);
    check("R6 jump before setup end", jump, 0);
    @(negedge clk);
    check("R6 jump after setup", jump, 1);
  endtask

  task automatic t_legal_advance();
    fuse_reset();
    adv(2'd1);
    check("R3 to secdbg", stage, 3'b001);
    check("R3 no err", adv_err, 0);
    check("R12 prot secdbg", prot, 1);
    adv(2'd3);
    check("R3 secdbg to rma", stage, 3'b111);
    fuse_reset();
    adv(2'd2);
    check("R3 to secure", stage, 3'b011);
    check("R12 prot secure", prot, 2);
    check("R10 secure closed", dbg, 4'h0);
    adv(2'd3);
    check("R3 secure to rma", stage, 3'b111);
    check("R12 prot rma", prot, 3);
    check("R10 rma open", dbg, 4'hF);
    check("R2 rma code", stage, 3'b111);
  endtask

  task automatic t_illegal();
    fuse_reset();
    adv(2'd0);
    check("R4 same stage err", adv_err, 1);
    check("R4 same stage kept", stage, 3'b000);
    @(negedge clk);
    check("R4 err one cycle", adv_err, 0);
    adv(2'd1);
    adv(2'd2);
    check("R4 secdbg to secure err", adv_err, 1);
    check("R4 secdbg kept", stage, 3'b001);
    adv(2'd0);
    check("R4 backward err", adv_err, 1);
    check("R4 backward kept", stage, 3'b001);
    fuse_reset();
    adv(2'd2);
    adv(2'd1);
    check("R4 secure to secdbg err", adv_err, 1);
    check("R4 secure kept", stage, 3'b011);
    adv(2'd3);
    adv(2'd2);
    check("R4 from rma err", adv_err, 1);
    check("R4 rma kept", stage, 3'b111);
    adv(2'd3);
    check("R4 rma to rma err", adv_err, 1);
  endtask

  task automatic t_persist();
    fuse_reset();
    adv(2'd2);
    warm_reset();
    check("R5 stage kept over warm reset", stage, 3'b011);
    check("R5 prot", prot, 2);
    fuse_reset();
    check("R5 fuse reset clears", stage, 3'b000);
  endtask

  task automatic t_secure_boot_ok();
    fuse_reset();
    adv(2'd1);
    warm_reset();
    wait_setup();
    check("R7 no jump before checks", jump, 0);
    hash_strobe(1'b1);
    check("R7 no jump after hash only", jump, 0);
    sig_strobe(1'b1);
    check("R7 jump after both", jump, 1);
    check("R12 prot secdbg booted", prot, 1);
    check("R10 secdbg open", dbg, 4'hF);
  endtask

  task automatic t_hash_fail();
    fuse_reset();
    dar_write(4'b0101);
    adv(2'd2);
    dar_write(4'b1111);
    warm_reset();
    wait_setup();
    hash_strobe(1'b0);
    check("R8 dead on hash fail", prot, 4);
    check("R8 no jump", jump, 0);
    check("R11 locked write ignored", dbg, 4'b0101);
    sig_strobe(1'b1);
    repeat (3) @(negedge clk);
    check("R8 dead persists", prot, 4);
    warm_reset();
    wait_setup();
    hash_strobe(1'b1);
    sig_strobe(1'b1);
    check("R8 rerun after reset", jump, 1);
    check("R10 secure booted closed", dbg, 4'h0);
  endtask

  task automatic t_sig_fail();
    fuse_reset();
    adv(2'd1);
    dar_write(4'b0011);
    warm_reset();
    wait_setup();
    hash_strobe(1'b1);
    sig_strobe(1'b0);
    check("R8 dead on sig fail", prot, 4);
    check("R10 dead mask", dbg, 4'b0011);
    check("R11 write in secdbg taken", dbg, 4'b0011);
    check("R8 no jump sig fail", jump, 0);
  endtask

  task automatic t_out_of_order();
    fuse_reset();
    adv(2'd2);
    warm_reset();
    wait_setup();
    sig_strobe(1'b1);
    check("R9 sig before hash", prot, 4);
    warm_reset();
    wait_setup();
    hash_strobe(1'b1);
    hash_strobe(1'b1);
    check("R9 second hash", prot, 4);
    warm_reset();
    @(negedge clk);
    hash_strobe(1'b1);
    repeat (S + 2) @(negedge clk);
    check("R9 strobe during setup", prot, 4);
    check("R9 no jump", jump, 0);
  endtask

  task automatic t_normal_rma_boot();
    fuse_reset();
    hash_strobe(1'b0);
    sig_strobe(1'b0);
    repeat (S) @(negedge clk);
    check("R6 normal ignores strobes", prot, 0);
    check("R6 normal jump", jump, 1);
    adv(2'd2);
    check("R12 live advance prot", prot, 2);
    check("R12 jump kept", jump, 1);
    fuse_reset();
    adv(2'd3);
    warm_reset();
    wait_setup();
    check("R6 rma jump", jump, 1);
    check("R6 rma prot", prot, 3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_legal_advance();
    t_illegal();
    t_persist();
    t_secure_boot_ok();
    t_hash_fail();
    t_sig_fail();
    t_out_of_order();
    t_normal_rma_boot();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule